// File: doc/BRIEF.md
# Down-converter per-channel configuration bank

This block is the configuration register file that sits in front of a multi-channel digital down-converter. Software writes 32-bit words into a bank of registers for each channel. The block turns those writes into registered configuration outputs for the filter chain and the mixer. It unpacks the decimation word into a halfband stage count and a CIC ratio, and clamps the stage count to the number of stages the datapath has. It pulses a strobe so the filter chain reloads. Reads of three read-only capability words let software learn how the datapath was built.

A write to the mixer phase increment can carry a command timestamp. Such a write is held pending and reaches the mixer only once the free-running timebase reaches the stamped time. An untimed write reaches the mixer at once. Each change of the phase increment is marked by its own strobe.

Top module: `ddc_cfg_bank`

## Requirements
- R1: After reset, every channel shows halfband count 0, CIC ratio 1, phase increment 0, I/Q scale 0, rate numerator 1, rate denominator 1 and time increment 0, with both strobes low.
- R2: Bits 11 and up of the byte address select the channel bank, so banks lie 2048 bytes apart. A write changes only the channel it selects.
- R3: A write reaches its register only when byte address bits [2:0] are zero. Bits [10:3] give the word index: 128 sets the rate numerator (N), 129 the rate denominator (M), 133 the I/Q scale and 137 the time increment. The new value is visible after the clock edge that samples the write.
- R4: Word index 134 is the decimation word. Bits [7:0] give the CIC ratio and bits [31:8] give the halfband count. A count larger than HB_STAGES is stored as HB_STAGES.
- R5: Each accepted decimation write raises decim_stb for that channel for the one cycle after the write edge. No other write raises it.
- R6: An untimed write to word index 132 loads the phase increment at the write edge and raises freq_stb for the following cycle.
- R7: A timed write to index 132 changes nothing at the write edge. It loads the phase increment at the first later edge where now_time is greater than or equal to the command time, and raises freq_stb for the cycle after that edge.
- R8: A new write to index 132 replaces a pending timed value. An untimed write also cancels that pending value.
- R9: A read returns data with rd_valid in the cycle after rd_en. Offset 0 returns COMPAT, offset 8 returns HB_STAGES and offset 16 returns CIC_MAX, in every channel bank. Any other offset returns 0.
- R10: Writes with nonzero address bits [2:0], and writes to any other word index (such as 130, 135 and 136), change no output and raise no strobe.
- R11: The phase increment output changes only in a cycle where freq_stb is high.

Where the stamped time is already reached when the timed write arrives, the value is loaded one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| wr_timed | input | 1 | Phase-increment write waits for wr_time |
| wr_time | input | TS_W | Command timestamp |
| now_time | input | TS_W | Free-running timebase |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid |
| hb_count | output | NUM_CH*HB_W | Halfband stages enabled per channel |
| cic_ratio | output | NUM_CH*8 | CIC decimation per channel |
| freq_word | output | NUM_CH*32 | Signed phase increment per channel |
| iq_scale | output | NUM_CH*32 | I/Q scale factor per channel |
| rate_n | output | NUM_CH*32 | Rate-change numerator N |
| rate_m | output | NUM_CH*32 | Rate-change denominator M |
| time_incr | output | NUM_CH*32 | Clock ticks per output sample group |
| decim_stb | output | NUM_CH | Filter-chain reload pulse |
| freq_stb | output | NUM_CH | Phase-increment update pulse |

## Verification
Plain registers, the decimation fields and untimed phase increments are due one clock edge after the write is sampled, together with their strobe. Read data is also due one edge after rd_en. The bench drives on the falling edge and samples on the next falling edge, so each check sees exactly one rising edge. A stamped write is checked over several edges: before the stamp, while the value must hold, and in the edge that reaches the stamp, where both the value and freq_stb must appear. A cancelled or replaced pending value is checked by stepping the timebase past the old stamp and confirming that nothing moves.

// File: rtl/ddc_cfg_pkg.sv
package ddc_cfg_pkg;
  localparam int BANK_BITS = 11;
  localparam logic [7:0] IDX_N     = 8'd128;
  localparam logic [7:0] IDX_M     = 8'd129;
  localparam logic [7:0] IDX_FREQ  = 8'd132;
  localparam logic [7:0] IDX_SCALE = 8'd133;
  localparam logic [7:0] IDX_DECIM = 8'd134;
  localparam logic [7:0] IDX_TINC  = 8'd137;

  // halfband field of the decimation word, clamped to the stages present
  function automatic int unsigned hb_field(input logic [31:0] w, input int unsigned stages);
    int unsigned req;
    req = int'(w[31:8]);
    return (req > stages) ? stages : req;
  endfunction

  // word index of an in-bank offset, or 0 when misaligned
  function automatic logic [7:0] word_idx(input logic [BANK_BITS-1:0] off);
    return (off[2:0] == 3'd0) ? off[BANK_BITS-1:3] : 8'd0;
  endfunction
endpackage

// File: rtl/ddc_addr_dec.sv
module ddc_addr_dec #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] hit_n,
  output logic [NUM_CH-1:0] hit_m,
  output logic [NUM_CH-1:0] hit_freq,
  output logic [NUM_CH-1:0] hit_scale,
  output logic [NUM_CH-1:0] hit_decim,
  output logic [NUM_CH-1:0] hit_tinc
);
  import ddc_cfg_pkg::*;
  localparam int SEL_W = ADDR_W - BANK_BITS;

  logic [7:0]       idx;
  logic [SEL_W-1:0] sel;
  assign idx = word_idx(wr_addr[BANK_BITS-1:0]);
  assign sel = wr_addr[ADDR_W-1:BANK_BITS];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic mine;
    assign mine         = wr_en && (sel == SEL_W'(c));
    assign hit_n[c]     = mine && (idx == IDX_N);
    assign hit_m[c]     = mine && (idx == IDX_M);
    assign hit_freq[c]  = mine && (idx == IDX_FREQ);
    assign hit_scale[c] = mine && (idx == IDX_SCALE);
    assign hit_decim[c] = mine && (idx == IDX_DECIM);
    assign hit_tinc[c]  = mine && (idx == IDX_TINC);
  end
endmodule

// File: rtl/ddc_chan_regs.sv
module ddc_chan_regs #(
  parameter int HB_STAGES = 3,
  parameter int HB_W      = 2,
  parameter int TS_W      = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     wdata,
  input  logic            timed,
  input  logic [TS_W-1:0] cmd_time,
  input  logic [TS_W-1:0] now_time,
  input  logic            hit_n,
  input  logic            hit_m,
  input  logic            hit_freq,
  input  logic            hit_scale,
  input  logic            hit_decim,
  input  logic            hit_tinc,
  output logic [HB_W-1:0] hb,
  output logic [7:0]      cic,
  output logic [31:0]     freq,
  output logic [31:0]     scale,
  output logic [31:0]     n_val,
  output logic [31:0]     m_val,
  output logic [31:0]     tinc,
  output logic            dec_stb,
  output logic            frq_stb
);
  import ddc_cfg_pkg::*;

  logic            pend;
  logic [31:0]     pend_val;
  logic [TS_W-1:0] pend_time;
  logic            due;
  assign due = pend && (now_time >= pend_time);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb <= '0; cic <= 8'd1; freq <= '0; scale <= '0;
      n_val <= 32'd1; m_val <= 32'd1; tinc <= '0;
      dec_stb <= 1'b0; frq_stb <= 1'b0;
      pend <= 1'b0; pend_val <= '0; pend_time <= '0;
    end else begin
      dec_stb <= hit_decim;
      frq_stb <= 1'b0;
      if (hit_n)     n_val <= wdata;
      if (hit_m)     m_val <= wdata;
      if (hit_scale) scale <= wdata;
      if (hit_tinc)  tinc  <= wdata;
      if (hit_decim) begin
        hb  <= HB_W'(hb_field(wdata, HB_STAGES));
        cic <= wdata[7:0];
      end
      if (hit_freq) begin
        if (timed) begin
          pend      <= 1'b1;
          pend_val  <= wdata;
          pend_time <= cmd_time;
        end else begin
          pend    <= 1'b0;
          freq    <= wdata;
          frq_stb <= 1'b1;
        end
      end else if (due) begin
        pend    <= 1'b0;
        freq    <= pend_val;
        frq_stb <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddc_cap_rd.sv
module ddc_cap_rd #(
  parameter int          ADDR_W    = 12,
  parameter int          HB_STAGES = 3,
  parameter int          CIC_MAX   = 128,
  parameter logic [31:0] COMPAT    = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  import ddc_cfg_pkg::*;
  logic [BANK_BITS-1:0] off;
  logic [31:0]          word;
  assign off = rd_addr[BANK_BITS-1:0];

  always_comb begin
    case (off)
      BANK_BITS'(0):  word = COMPAT;
      BANK_BITS'(8):  word = 32'(HB_STAGES);
      BANK_BITS'(16): word = 32'(CIC_MAX);
      default:        word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end
endmodule

// File: rtl/ddc_cfg_bank.sv
module ddc_cfg_bank #(
  parameter int          NUM_CH    = 2,
  parameter int          HB_STAGES = 3,
  parameter int          CIC_MAX   = 128,
  parameter int          TS_W      = 64,
  parameter logic [31:0] COMPAT    = 32'h0000_0001,
  localparam int         CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int         ADDR_W    = 11 + CH_W,
  localparam int         HB_W      = $clog2(HB_STAGES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic                   wr_timed,
  input  logic [TS_W-1:0]        wr_time,
  input  logic [TS_W-1:0]        now_time,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [31:0]            rd_data,
  output logic                   rd_valid,
  output logic [NUM_CH*HB_W-1:0] hb_count,
  output logic [NUM_CH*8-1:0]    cic_ratio,
  output logic [NUM_CH*32-1:0]   freq_word,
  output logic [NUM_CH*32-1:0]   iq_scale,
  output logic [NUM_CH*32-1:0]   rate_n,
  output logic [NUM_CH*32-1:0]   rate_m,
  output logic [NUM_CH*32-1:0]   time_incr,
  output logic [NUM_CH-1:0]      decim_stb,
  output logic [NUM_CH-1:0]      freq_stb
);
  logic [NUM_CH-1:0] hit_n, hit_m, hit_freq, hit_scale, hit_decim, hit_tinc;

  ddc_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr),
    .hit_n(hit_n), .hit_m(hit_m), .hit_freq(hit_freq),
    .hit_scale(hit_scale), .hit_decim(hit_decim), .hit_tinc(hit_tinc)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    ddc_chan_regs #(.HB_STAGES(HB_STAGES), .HB_W(HB_W), .TS_W(TS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wdata(wr_data), .timed(wr_timed),
      .cmd_time(wr_time), .now_time(now_time),
      .hit_n(hit_n[c]), .hit_m(hit_m[c]), .hit_freq(hit_freq[c]),
      .hit_scale(hit_scale[c]), .hit_decim(hit_decim[c]), .hit_tinc(hit_tinc[c]),
      .hb(hb_count[c*HB_W +: HB_W]), .cic(cic_ratio[c*8 +: 8]),
      .freq(freq_word[c*32 +: 32]), .scale(iq_scale[c*32 +: 32]),
      .n_val(rate_n[c*32 +: 32]), .m_val(rate_m[c*32 +: 32]),
      .tinc(time_incr[c*32 +: 32]),
      .dec_stb(decim_stb[c]), .frq_stb(freq_stb[c])
    );
  end

  ddc_cap_rd #(.ADDR_W(ADDR_W), .HB_STAGES(HB_STAGES), .CIC_MAX(CIC_MAX),
               .COMPAT(COMPAT)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/ddc_cfg_bank_chk.sv
module ddc_cfg_bank_chk #(
  parameter int NUM_CH    = 2,
  parameter int HB_STAGES = 3,
  parameter int HB_W      = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_en,
  input logic                   rd_valid,
  input logic [NUM_CH-1:0]      hit_decim,
  input logic [NUM_CH-1:0]      decim_stb,
  input logic [NUM_CH*HB_W-1:0] hb_count,
  input logic [NUM_CH*32-1:0]   freq_word,
  input logic [NUM_CH-1:0]      freq_stb
);
  // R9
  rd_valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R5
    decim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_decim[c] |=> decim_stb[c]);
    // R5
    decim_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decim_stb[c] |-> $past(hit_decim[c]));
    // R4
    hb_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(hb_count[c*HB_W +: HB_W]) <= HB_STAGES);
    // R11
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_stb[c] |-> $stable(freq_word[c*32 +: 32]));
  end
endmodule

bind ddc_cfg_bank ddc_cfg_bank_chk #(.NUM_CH(NUM_CH), .HB_STAGES(HB_STAGES), .HB_W(HB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .hit_decim(hit_decim), .decim_stb(decim_stb), .hb_count(hb_count),
  .freq_word(freq_word), .freq_stb(freq_stb)
);

// File: tb/ddc_cfg_bank_bench.sv
module ddc_cfg_bank_bench;
  localparam int NCH = 2, HBS = 3, CMAX = 128, TSW = 64, AW = 12, HBW = 2;
  localparam logic [31:0] CPT = 32'h0000_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_timed = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [TSW-1:0] wr_time = '0, now_time = '0;
  logic [31:0] rd_data;
  logic rd_valid;
  logic [NCH*HBW-1:0] hb_count;
  logic [NCH*8-1:0] cic_ratio;
  logic [NCH*32-1:0] freq_word, iq_scale, rate_n, rate_m, time_incr;
  logic [NCH-1:0] decim_stb, freq_stb;

  always #4 clk = ~clk;

  ddc_cfg_bank #(.NUM_CH(NCH), .HB_STAGES(HBS), .CIC_MAX(CMAX), .TS_W(TSW), .COMPAT(CPT)) u_ddc_cfg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_timed(wr_timed), .wr_time(wr_time), .now_time(now_time),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .hb_count(hb_count), .cic_ratio(cic_ratio), .freq_word(freq_word),
    .iq_scale(iq_scale), .rate_n(rate_n), .rate_m(rate_m), .time_incr(time_incr),
    .decim_stb(decim_stb), .freq_stb(freq_stb));

  int total = 0, bad = 0;
  bit ended = 0;
  logic [31:0] m_hb[NCH], m_cic[NCH], m_frq[NCH], m_scl[NCH], m_n[NCH], m_m[NCH], m_ti[NCH];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_hb(input logic [31:0] w);
    return (w >> 8) > HBS ? HBS : (w >> 8);
  endfunction

  function automatic logic [AW-1:0] baddr(input int ch, input int idx);
    return AW'(ch * 2048 + idx * 8);
  endfunction

  task automatic wr(input int ch, input int idx, input logic [31:0] d,
                    input bit tm = 0, input logic [63:0] t = 0);
    wr_en = 1; wr_addr = baddr(ch, idx); wr_data = d; wr_timed = tm; wr_time = t;
    @(negedge clk);
    wr_en = 0; wr_timed = 0;
    if (!tm) begin
      case (idx)
        128: m_n[ch] = d;
        129: m_m[ch] = d;
        132: m_frq[ch] = d;
        133: m_scl[ch] = d;
        134: begin m_hb[ch] = exp_hb(d); m_cic[ch] = {24'd0, d[7:0]}; end
        137: m_ti[ch] = d;
        default: ;
      endcase
    end
  endtask

  task automatic cmp_all(input string req, input logic [NCH-1:0] ds, input logic [NCH-1:0] fs);
    for (int c = 0; c < NCH; c++) begin
      chk(req, hb_count[c*HBW +: HBW], m_hb[c]);
      chk(req, cic_ratio[c*8 +: 8], m_cic[c]);
      chk(req, freq_word[c*32 +: 32], m_frq[c]);
      chk(req, iq_scale[c*32 +: 32], m_scl[c]);
      chk(req, rate_n[c*32 +: 32], m_n[c]);
      chk(req, rate_m[c*32 +: 32], m_m[c]);
      chk(req, time_incr[c*32 +: 32], m_ti[c]);
    end
    chk(req, decim_stb, ds);
    chk(req, freq_stb, fs);
  endtask

  task automatic rd(input int ch, input int off, input logic [31:0] exp, input string req);
    rd_en = 1; rd_addr = AW'(ch * 2048 + off);
    @(negedge clk);
    rd_en = 0;
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
    @(negedge clk);
    chk(req, rd_valid, 0);
  endtask

  initial begin
    #1_000_000;
    if (!ended) begin
      ended = 1; total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin
      m_hb[c] = 0; m_cic[c] = 1; m_frq[c] = 0; m_scl[c] = 0; m_n[c] = 1; m_m[c] = 1; m_ti[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_all("R1 reset", '0, '0);

    // R3 plain registers, channel 0; R2 channel 1 untouched
    wr(0, 128, 32'd12);  cmp_all("R3 N", '0, '0);
    wr(0, 129, 32'd1);   cmp_all("R3 M", '0, '0);
    wr(0, 133, 32'h4000); cmp_all("R3 scale", '0, '0);
    wr(0, 137, 32'd77);  cmp_all("R3 tinc", '0, '0);
    wr(1, 137, 32'd99);  cmp_all("R2 bank1 tinc", '0, '0);

    // R4 / R5 decimation fields and strobe
    wr(1, 134, 32'h0000_0205); cmp_all("R4 decim 2/5", 2'b10, '0);
    @(negedge clk); cmp_all("R5 strobe one cycle", '0, '0);
    wr(0, 134, 32'h0000_0940); cmp_all("R4 clamp", 2'b01, '0);
    chk("R4 clamp hb", hb_count[0 +: HBW], HBS);

    // R6 untimed frequency
    wr(1, 132, 32'hF000_0001); cmp_all("R6 untimed", '0, 2'b10);
    @(negedge clk); cmp_all("R6 stb drop", '0, '0);

    // R7 timed frequency
    now_time = 64'd100;
    wr(0, 132, 32'h1234_5678, 1, 64'd105); cmp_all("R7 held at write", '0, '0);
    now_time = 64'd104; @(negedge clk); cmp_all("R7 before stamp", '0, '0);
    now_time = 64'd105; @(negedge clk);
    m_frq[0] = 32'h1234_5678; cmp_all("R7 at stamp", '0, 2'b01);
    @(negedge clk); cmp_all("R7 after", '0, '0);
    // R7 stamp already passed: loads one edge later
    wr(1, 132, 32'hAA, 1, 64'd50); cmp_all("R7 past stamp write edge", '0, '0);
    @(negedge clk); m_frq[1] = 32'hAA; cmp_all("R7 past stamp next edge", '0, 2'b10);

    // R8 replace and cancel
    wr(0, 132, 32'h111, 1, 64'd200);
    wr(0, 132, 32'h222, 1, 64'd210);
    now_time = 64'd205; @(negedge clk); cmp_all("R8 old stamp ignored", '0, '0);
    now_time = 64'd210; @(negedge clk); m_frq[0] = 32'h222; cmp_all("R8 replaced", '0, 2'b01);
    wr(1, 132, 32'h333, 1, 64'd300);
    wr(1, 132, 32'h444); cmp_all("R8 untimed cancels", '0, 2'b10);
    now_time = 64'd400; @(negedge clk); cmp_all("R8 cancelled stays", '0, '0);

    // R10 ignored writes
    wr(0, 130, 32'hDEAD); cmp_all("R10 idx130", '0, '0);
    wr(0, 135, 32'hDEAD); cmp_all("R10 idx135", '0, '0);
    wr(1, 136, 32'hDEAD); cmp_all("R10 idx136", '0, '0);
    wr_en = 1; wr_addr = baddr(0, 134) | AW'(4); wr_data = 32'h0103;
    @(negedge clk); wr_en = 0; cmp_all("R10 misaligned", '0, '0);

    // R9 capability readback
    rd(0, 0, CPT, "R9 compat");
    rd(1, 8, HBS, "R9 stages");
    rd(1, 16, CMAX, "R9 cicmax");
    rd(0, 24, 0, "R9 other");

    // random untimed writes, R3 R4 R5 R6 R11
    for (int i = 0; i < 300; i++) begin
      int ch, sel, idx;
      logic [31:0] d;
      ch = int'($urandom_range(NCH - 1));
      sel = int'($urandom_range(7));
      d = $urandom;
      if (sel == 6) d = {16'd0, d[15:0]};
      case (sel)
        0: idx = 128; 1: idx = 129; 2: idx = 132; 3: idx = 133;
        4: idx = 137; 5: idx = 130; default: idx = 134;
      endcase
      wr(ch, idx, d);
      cmp_all("R3 random", (idx == 134) ? NCH'(1 << ch) : '0,
              (idx == 132) ? NCH'(1 << ch) : '0);
    end

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule